// File: doc/BRIEF.md
# Ones-Complement Timer Interrupt Unit

This block keeps four ones-complement timer counters and a latch of pending timer interrupts served in a fixed priority order. Three of the timers count up. They all advance on a slow strobe with a nominal 10 ms period. Each one raises its interrupt when it steps past the largest positive value. The fourth timer counts toward zero on a fast strobe with a nominal 1/1600 s period, and only while its enable bit is set. It fires only when a step lands on a counter that already holds plus or minus zero. That step also clears its enable bit.

One prescaler produces both strobes from the system clock. Its dividers are parameters. Software writes and reads each counter through one register port. The enable bit has its own channel write. A global inhibit input masks the interrupt request line but does not stop flags from collecting. A service pulse takes the highest-priority pending flag, clears only that flag, and the unit shows that flag's vector number while the flag is pending.

Top module: `tmr_irq_unit`

## Requirements
- R1: After reset all four counters read plus zero, the down-timer enable is clear, no flag is pending, `svc_none` is 1, `svc_vec` is 0 and `irq_req` is 0.
- R2: A value written with select code 0 (timer 3), 1 (timer 4), 2 (timer 5) or 3 (down timer) reads back unchanged on `rd_data` in the cycle after the write, until that counter next steps.
- R3: Each slow strobe adds one to every up-counter in ones-complement form. Minus zero (all ones) steps to plus one, and minus one steps to minus zero.
- R4: An up-counter that steps while it holds the largest positive value (sign clear, all other bits set) wraps to plus zero, sets its pending flag and keeps counting from there.
- R5: A second overflow of a timer whose flag is still pending merges into that flag. A single service then clears it.
- R6: While enabled, the down timer steps exactly once per fast strobe. A positive value drops by one and a negative value rises by one. Plus one steps to minus zero without a flag, and the enable stays set.
- R7: A step on a down timer that holds plus zero or minus zero leaves the value unchanged, sets the down timer's flag and clears the enable bit.
- R8: The channel write sets or clears the enable bit, shown on `down_en`. While the bit is clear the down timer holds its value.
- R9: A counter write in the same cycle as that counter's strobe wins, and the step is dropped.
- R10: `pending` bit 0 is timer 3, bit 1 is timer 4, bit 2 is timer 5 and bit 3 is the down timer. Flags set while `inhibit` is 1 are kept. `irq_req` is 1 exactly when some flag is pending and `inhibit` is 0.
- R11: `svc_vec` names the winner as 6 (down timer), 5, 3 or 4, in that priority order. A `svc_req` cycle clears only the winner's flag.
- R12: With no flag pending, `svc_none` is 1 and `svc_vec` is 0. A service request then changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Counter write strobe |
| wr_sel | input | 2 | Counter selected for write (0: T3, 1: T4, 2: T5, 3: down timer) |
| wr_data | input | WIDTH | Value to load |
| rd_sel | input | 2 | Counter selected for read, same coding |
| rd_data | output | WIDTH | Current value of the selected counter |
| en_wr | input | 1 | Enable-channel write strobe |
| en_wdata | input | 1 | New enable bit for the down timer |
| down_en | output | 1 | Current down-timer enable |
| inhibit | input | 1 | Masks `irq_req`; flags still collect |
| irq_req | output | 1 | Some flag pending and not inhibited |
| svc_req | input | 1 | Service pulse: clears the winning flag |
| svc_vec | output | 3 | Vector number of the winner, 0 when none |
| svc_none | output | 1 | No flag pending |
| pending | output | 4 | Pending flags {down, T5, T4, T3} |

## Verification
The bench uses a 5-bit counter width so that every value fits in one sweep. Every down-timer value is loaded and stepped once, which separates the positive, negative, plus-one and both-zero branches. Every up-timer value is loaded and stepped on each of the three up timers, which separates plain increments, the minus-zero step and the overflow wrap. Writes placed exactly on a strobe edge test the write-wins rule. A combined run arms all four timers under inhibit. It watches the down timer pass through minus zero without firing, then drains the four flags and expects 6, 5, 3, 4, followed by the none indication.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;

   localparam int unsigned NUM_TMR  = 4;
   localparam int unsigned VEC_W    = 3;
   localparam int unsigned VEC_BASE = 3;

   // Flag/select slot of each timer; vector number is VEC_BASE + slot.
   typedef enum logic [1:0] {
      SEL_T3   = 2'd0,
      SEL_T4   = 2'd1,
      SEL_T5   = 2'd2,
      SEL_DOWN = 2'd3
   } tmr_sel_e;

   // Slot served at a given rank, rank 0 being served first.
   function automatic int unsigned prio_slot(input int unsigned rank);
      case (rank)
         0:       return 3;
         1:       return 2;
         2:       return 0;
         default: return 1;
      endcase
   endfunction

endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
   parameter int unsigned FAST_DIV   = 78125,
   parameter int unsigned SLOW_RATIO = 16
) (
   input  logic clk,
   input  logic rst_n,
   output logic fast_tick,
   output logic slow_tick
);

   localparam int unsigned FW = (FAST_DIV > 1) ? $clog2(FAST_DIV) : 1;
   localparam logic [FW-1:0] F_LAST = FW'(FAST_DIV - 1);

   logic [FW-1:0] fcnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               fcnt_q <= '0;
      else if (fcnt_q == F_LAST) fcnt_q <= '0;
      else                      fcnt_q <= fcnt_q + 1'b1;
   end

   assign fast_tick = (fcnt_q == F_LAST);

   generate
      if (SLOW_RATIO == 1) begin : g_direct
         assign slow_tick = fast_tick;
      end else begin : g_ratio
         localparam int unsigned SW = $clog2(SLOW_RATIO);
         localparam logic [SW-1:0] S_LAST = SW'(SLOW_RATIO - 1);
         logic [SW-1:0] scnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) scnt_q <= '0;
            else if (fast_tick) begin
               if (scnt_q == S_LAST) scnt_q <= '0;
               else                  scnt_q <= scnt_q + 1'b1;
            end
         end
         assign slow_tick = fast_tick & (scnt_q == S_LAST);
      end
   endgenerate

endmodule

// File: rtl/tmr_up_cnt.sv
module tmr_up_cnt #(
   parameter int unsigned WIDTH = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_i,
   input  logic             wr_i,
   input  logic [WIDTH-1:0] wdata_i,
   output logic [WIDTH-1:0] val_o,
   output logic             ovf_o
);

   localparam logic [WIDTH-1:0] MAX_POS  = {1'b0, {(WIDTH-1){1'b1}}};
   localparam logic [WIDTH-1:0] NEG_ZERO = '1;
   localparam logic [WIDTH-1:0] ONE      = WIDTH'(1);

   logic [WIDTH-1:0] val_q, inc;
   logic             at_max;

   assign at_max = (val_q == MAX_POS);

   always_comb begin
      if (at_max)                 inc = '0;
      else if (val_q == NEG_ZERO) inc = ONE;
      else                        inc = val_q + ONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      val_q <= '0;
      else if (wr_i)   val_q <= wdata_i;
      else if (step_i) val_q <= inc;
   end

   assign ovf_o = step_i & ~wr_i & at_max;
   assign val_o = val_q;

endmodule

// File: rtl/tmr_down_cnt.sv
module tmr_down_cnt #(
   parameter int unsigned WIDTH = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_i,
   input  logic             wr_i,
   input  logic [WIDTH-1:0] wdata_i,
   input  logic             en_wr_i,
   input  logic             en_wdata_i,
   output logic [WIDTH-1:0] val_o,
   output logic             en_o,
   output logic             fire_o
);

   localparam logic [WIDTH-1:0] NEG_ZERO = '1;
   localparam logic [WIDTH-1:0] ONE      = WIDTH'(1);

   logic [WIDTH-1:0] val_q, toward;
   logic             en_q, is_zero, stepping;

   assign is_zero  = (val_q == '0) | (val_q == NEG_ZERO);
   assign stepping = step_i & en_q & ~wr_i;
   assign fire_o   = stepping & is_zero;

   always_comb begin
      if (val_q == ONE)          toward = NEG_ZERO;
      else if (!val_q[WIDTH-1])  toward = val_q - ONE;
      else                       toward = val_q + ONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    val_q <= '0;
      else if (wr_i)                 val_q <= wdata_i;
      else if (stepping && !is_zero) val_q <= toward;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       en_q <= 1'b0;
      else if (en_wr_i) en_q <= en_wdata_i;
      else if (fire_o)  en_q <= 1'b0;
   end

   assign val_o = val_q;
   assign en_o  = en_q;

endmodule

// File: rtl/tmr_irq_arbiter.sv
module tmr_irq_arbiter
   import tmr_irq_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_TMR-1:0] set_i,
   input  logic               svc_req_i,
   output logic [NUM_TMR-1:0] pend_o,
   output logic [VEC_W-1:0]   vec_o,
   output logic               none_o
);

   logic [NUM_TMR-1:0] pend_q, grant;
   logic [NUM_TMR:0]   blocked;

   assign blocked[0] = 1'b0;

   for (genvar r = 0; r < NUM_TMR; r++) begin : g_rank
      localparam int unsigned SLOT = prio_slot(r);
      assign grant[SLOT]  = pend_q[SLOT] & ~blocked[r];
      assign blocked[r+1] = blocked[r] | pend_q[SLOT];
   end

   always_comb begin
      vec_o = '0;
      for (int i = 0; i < NUM_TMR; i++) begin
         if (grant[i]) vec_o = VEC_W'(VEC_BASE + i);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~(svc_req_i ? grant : '0)) | set_i;
   end

   assign none_o = ~|pend_q;
   assign pend_o = pend_q;

endmodule

// File: rtl/tmr_irq_unit.sv
module tmr_irq_unit
   import tmr_irq_pkg::*;
#(
   parameter int unsigned WIDTH      = 15,
   parameter int unsigned FAST_DIV   = 78125,
   parameter int unsigned SLOW_RATIO = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [WIDTH-1:0] wr_data,
   input  logic [1:0]       rd_sel,
   output logic [WIDTH-1:0] rd_data,
   input  logic             en_wr,
   input  logic             en_wdata,
   output logic             down_en,
   input  logic             inhibit,
   output logic             irq_req,
   input  logic             svc_req,
   output logic [2:0]       svc_vec,
   output logic             svc_none,
   output logic [3:0]       pending
);

   localparam int unsigned NUM_UP = NUM_TMR - 1;

   if (WIDTH < 3) begin : g_bad_width
      $error("tmr_irq_unit: WIDTH must be at least 3");
   end
   if (FAST_DIV < 2) begin : g_bad_div
      $error("tmr_irq_unit: FAST_DIV must be at least 2");
   end
   if (SLOW_RATIO < 1) begin : g_bad_ratio
      $error("tmr_irq_unit: SLOW_RATIO must be at least 1");
   end

   logic               fast_tick, slow_tick;
   logic [WIDTH-1:0]   up_val [NUM_UP];
   logic [WIDTH-1:0]   down_val;
   logic [NUM_TMR-1:0] set_vec;

   tmr_tick_gen #(
      .FAST_DIV  (FAST_DIV),
      .SLOW_RATIO(SLOW_RATIO)
   ) i_tick (
      .clk      (clk),
      .rst_n    (rst_n),
      .fast_tick(fast_tick),
      .slow_tick(slow_tick)
   );

   for (genvar i = 0; i < NUM_UP; i++) begin : g_up
      tmr_up_cnt #(.WIDTH(WIDTH)) i_up (
         .clk    (clk),
         .rst_n  (rst_n),
         .step_i (slow_tick),
         .wr_i   (wr_en && (wr_sel == 2'(i))),
         .wdata_i(wr_data),
         .val_o  (up_val[i]),
         .ovf_o  (set_vec[i])
      );
   end

   tmr_down_cnt #(.WIDTH(WIDTH)) i_down (
      .clk       (clk),
      .rst_n     (rst_n),
      .step_i    (fast_tick),
      .wr_i      (wr_en && (wr_sel == SEL_DOWN)),
      .wdata_i   (wr_data),
      .en_wr_i   (en_wr),
      .en_wdata_i(en_wdata),
      .val_o     (down_val),
      .en_o      (down_en),
      .fire_o    (set_vec[SEL_DOWN])
   );

   tmr_irq_arbiter i_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (set_vec),
      .svc_req_i(svc_req),
      .pend_o   (pending),
      .vec_o    (svc_vec),
      .none_o   (svc_none)
   );

   always_comb begin
      case (rd_sel)
         SEL_T3:  rd_data = up_val[0];
         SEL_T4:  rd_data = up_val[1];
         SEL_T5:  rd_data = up_val[2];
         default: rd_data = down_val;
      endcase
   end

   assign irq_req = ~inhibit & ~svc_none;

endmodule

// File: rtl/tmr_irq_checker.sv
module tmr_irq_checker #(
   parameter int unsigned WIDTH = 15
) (
   input logic             clk,
   input logic             rst_n,
   input logic             inhibit,
   input logic             irq_req,
   input logic             svc_req,
   input logic             svc_none,
   input logic [2:0]       svc_vec,
   input logic [3:0]       pending,
   input logic             down_en,
   input logic             en_wr,
   input logic             wr_en,
   input logic [1:0]       wr_sel,
   input logic [WIDTH-1:0] down_val
);

   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      inhibit |-> !irq_req);  // R10

   AST_FLAGS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      !svc_req |=> (($past(pending) & ~pending) == 4'b0));  // R10

   AST_ONE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      svc_req |=> ($countones($past(pending) & ~pending) <= 1));  // R11

   AST_DOWN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      pending[3] |-> (svc_vec == 3'd6));  // R11

   AST_NONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      svc_none |-> (svc_vec == 3'd0 && pending == 4'b0));  // R12

   AST_FIRE_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pending[3]) && !$past(en_wr)) |-> !down_en);  // R7

   AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!down_en && !(wr_en && wr_sel == 2'd3)) |=> (down_val == $past(down_val)));  // R8

endmodule

bind tmr_irq_unit tmr_irq_checker #(.WIDTH(WIDTH)) i_tmr_irq_checker (
   .clk     (clk),
   .rst_n   (rst_n),
   .inhibit (inhibit),
   .irq_req (irq_req),
   .svc_req (svc_req),
   .svc_none(svc_none),
   .svc_vec (svc_vec),
   .pending (pending),
   .down_en (down_en),
   .en_wr   (en_wr),
   .wr_en   (wr_en),
   .wr_sel  (wr_sel),
   .down_val(down_val)
);

// File: tb/test_tmr_irq_unit.sv
module test_tmr_irq_unit;

   localparam int W    = 5;
   localparam int DIV  = 4;
   localparam int RAT  = 4;
   localparam int SLOW = DIV * RAT;
   localparam int MAXP = (1 << (W - 1)) - 1;
   localparam int ALL1 = (1 << W) - 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [1:0]   wr_sel = 2'd0;
   logic [W-1:0] wr_data = '0;
   logic [1:0]   rd_sel = 2'd0;
   logic [W-1:0] rd_data;
   logic         en_wr = 1'b0;
   logic         en_wdata = 1'b0;
   logic         down_en;
   logic         inhibit = 1'b0;
   logic         irq_req;
   logic         svc_req = 1'b0;
   logic [2:0]   svc_vec;
   logic         svc_none;
   logic [3:0]   pending;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit done   = 1'b0;

   tmr_irq_unit #(.WIDTH(W), .FAST_DIV(DIV), .SLOW_RATIO(RAT)) i_tmr_irq_unit (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd_sel(rd_sel), .rd_data(rd_data), .en_wr(en_wr), .en_wdata(en_wdata),
      .down_en(down_en), .inhibit(inhibit), .irq_req(irq_req), .svc_req(svc_req),
      .svc_vec(svc_vec), .svc_none(svc_none), .pending(pending)
   );

   always #4 clk = ~clk;

   always @(posedge clk) begin
      if (rst_n) cyc <= cyc + 1;
      else       cyc <= 0;
   end

   function automatic int up_next(input int v);
      if (v == MAXP) return 0;
      if (v == ALL1) return 1;
      return v + 1;
   endfunction

   function automatic int dn_next(input int v);
      if (v == 1) return ALL1;
      if (v <= MAXP) return v - 1;
      return v + 1;
   endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic wait_phase(input int per, input int ph);
      do @(negedge clk); while ((cyc % per) != ph);
   endtask

   task automatic rd(input int s, output int v);
      rd_sel = 2'(s);
      #1;
      v = int'(rd_data);
   endtask

   task automatic wr(input int s, input int v, input bit en);
      wr_en = 1'b1; wr_sel = 2'(s); wr_data = W'(v);
      en_wr = en; en_wdata = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; en_wr = 1'b0;
   endtask

   task automatic en_set(input bit b);
      en_wr = 1'b1; en_wdata = b;
      @(negedge clk);
      en_wr = 1'b0;
   endtask

   task automatic serve(output int vec);
      vec = int'(svc_vec);
      svc_req = 1'b1;
      @(negedge clk);
      svc_req = 1'b0;
   endtask

   task automatic drain();
      int d;
      for (int n = 0; n < 8 && !svc_none; n++) serve(d);
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not complete");
         finish_run();
      end
   end

   initial begin
      int v, vec;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk("R1", "pending", int'(pending), 0);
      chk("R1", "svc_none", int'(svc_none), 1);
      chk("R1", "svc_vec", int'(svc_vec), 0);
      chk("R1", "down_en", int'(down_en), 0);
      chk("R1", "irq_req", int'(irq_req), 0);
      for (int s = 0; s < 4; s++) begin
         rd(s, v);
         chk("R1", "counter", v, 0);
      end

      // R2, R6, R7: every down-timer value stepped once
      for (int x = 0; x <= ALL1; x++) begin
         wait_phase(DIV, 1);
         wr(3, x, 1'b1);
         rd(3, v);
         chk("R2", "down readback", v, x);
         wait_phase(DIV, 0);
         rd(3, v);
         if (x == 0 || x == ALL1) begin
            chk("R7", "zero value kept", v, x);
            chk("R7", "down flag", int'(pending[3]), 1);
            chk("R7", "enable dropped", int'(down_en), 0);
            serve(vec);
            chk("R11", "down vector", vec, 6);
            chk("R7", "flag cleared", int'(pending[3]), 0);
         end else begin
            chk("R6", "step toward zero", v, dn_next(x));
            chk("R6", "enable kept", int'(down_en), 1);
            chk("R6", "no flag", int'(pending[3]), 0);
         end
      end

      // R8: enable channel and hold while disabled
      en_set(1'b1);
      chk("R8", "enable set", int'(down_en), 1);
      en_set(1'b0);
      chk("R8", "enable cleared", int'(down_en), 0);
      wr(3, 5, 1'b0);
      repeat (3 * DIV) @(negedge clk);
      rd(3, v);
      chk("R8", "held while off", v, 5);

      // R9: write on the strobe edge wins
      wait_phase(DIV, DIV - 1);
      wr(3, 10, 1'b1);
      rd(3, v);
      chk("R9", "down write wins", v, 10);
      wait_phase(DIV, 0);
      rd(3, v);
      chk("R6", "next step", v, 9);
      en_set(1'b0);
      wait_phase(SLOW, SLOW - 1);
      wr(1, 7, 1'b0);
      rd(1, v);
      chk("R9", "up write wins", v, 7);
      wait_phase(SLOW, 0);
      rd(1, v);
      chk("R3", "after dropped step", v, 8);

      // R2, R3, R4: every value on every up timer
      for (int s = 0; s < 3; s++) begin
         for (int x = 0; x <= ALL1; x++) begin
            wait_phase(SLOW, 1);
            wr(s, x, 1'b0);
            for (int o = 0; o < 3; o++) if (o != s) wr(o, 0, 1'b0);
            drain();
            rd(s, v);
            chk("R2", "up readback", v, x);
            wait_phase(SLOW, 0);
            rd(s, v);
            chk("R3", "up step", v, up_next(x));
            chk("R4", "overflow flag", int'(pending[s]), (x == MAXP) ? 1 : 0);
            if (x == MAXP) begin
               wait_phase(SLOW, 0);
               rd(s, v);
               chk("R4", "counts on after wrap", v, 1);
            end
         end
      end

      // R5: second overflow merges into the pending flag
      wait_phase(SLOW, 1);
      wr(2, MAXP, 1'b0);
      wr(0, 0, 1'b0);
      wr(1, 0, 1'b0);
      drain();
      wait_phase(SLOW, 0);
      chk("R5", "first overflow", int'(pending), 4);
      wait_phase(SLOW, 1);
      wr(2, MAXP, 1'b0);
      wait_phase(SLOW, 0);
      chk("R5", "still one flag", int'(pending), 4);
      serve(vec);
      chk("R5", "vector", vec, 5);
      chk("R5", "single service clears", int'(svc_none), 1);

      // R10, R11, R12: all four armed under inhibit
      inhibit = 1'b1;
      wait_phase(SLOW, 1);
      wr(0, MAXP, 1'b0);
      wr(1, MAXP, 1'b0);
      wr(2, MAXP, 1'b0);
      wr(3, 2, 1'b1);
      wait_phase(SLOW, 12);
      rd(3, v);
      chk("R6", "reached minus zero", v, ALL1);
      chk("R6", "enable at minus zero", int'(down_en), 1);
      chk("R6", "no flag at minus zero", int'(pending), 0);
      wait_phase(SLOW, 0);
      #1;
      chk("R10", "all pending", int'(pending), 15);
      chk("R7", "enable dropped", int'(down_en), 0);
      chk("R10", "masked", int'(irq_req), 0);
      serve(vec); chk("R11", "first", vec, 6);
      chk("R11", "only winner cleared", int'(pending), 7);
      serve(vec); chk("R11", "second", vec, 5);
      serve(vec); chk("R11", "third", vec, 3);
      chk("R11", "only winner cleared", int'(pending), 2);
      serve(vec); chk("R11", "fourth", vec, 4);
      #1;
      chk("R12", "none", int'(svc_none), 1);
      chk("R12", "vector zero", int'(svc_vec), 0);
      serve(vec);
      chk("R12", "idle service", int'(pending), 0);
      inhibit = 1'b0;
      #1;
      chk("R10", "no request when empty", int'(irq_req), 0);
      wait_phase(DIV, 1);
      wr(3, 0, 1'b1);
      wait_phase(DIV, 0);
      #1;
      chk("R10", "request raised", int'(irq_req), 1);
      inhibit = 1'b1;
      #1;
      chk("R10", "request masked", int'(irq_req), 0);
      chk("R10", "flag kept", int'(pending), 8);
      inhibit = 1'b0;
      serve(vec);
      chk("R11", "down vector", vec, 6);

      done = 1'b1;
      finish_run();
   end

endmodule